// File: doc/BRIEF.md
# Debug Scan Register Access Port

This block is a test-access data register that gives an external debugger read and write access to a bank of internal 32-bit registers. A standard TAP controller, which is outside the block, runs it through per-cycle strobes. The block sees instruction-update pulses together with the current instruction code. It also receives capture, shift and update strobes for the data path, plus the serial input. It drives the serial output and a simple request/acknowledge register bus.

Each access takes two data scans through one shared 34-bit chain. The first scan carries a register index and a direction bit. The second scan carries the 32-bit value, either into the block (write) or out of it (read). Every capture loads a busy flag and a sticky error flag into the lowest bits, so the debugger sees status before any data. If the busy flag was set at capture, the scan does not move the block forward. The debugger can then repeat the same scan until the register bus has finished.

Top module: `dbg_scan_port`

## Requirements
- R1: After reset, tdo is 0, bus_req is 0, the block is in the address phase, and the error flag is clear.
- R2: An instruction-update pulse with code 5'h10 selects the block. It forces the address phase and clears the error flag. An update with any other code deselects the block, and then capture, shift and update strobes cause no bus request.
- R3: The chain is 34 bits long. Each shift strobe moves tdi into bit 33, and tdo always presents bit 0, so bits leave least significant first.
- R4: A capture loads bit 0 with busy and bit 1 with error. Bits 33:2 hold the last read value in the data phase of a read, and zero in every other phase.
- R5: In the address phase, bits 33:27 of the scanned word give the register index and bit 26 gives the direction (1 = read, 0 = write). For a read, the update that ends this scan issues a bus request with bus_we = 0.
- R6: In the data phase of a write, bits 33:2 give the value. The update that ends this scan issues a bus request with bus_we = 1 and that value on bus_wdata.
- R7: The phase toggles between address and data on each update whose capture saw busy clear. If busy was set at capture, the phase is kept and no request is issued.
- R8: A read data scan that shifts fewer than 34 bits still toggles the phase back to address at its update.
- R9: Busy stays set from the issue of a request until bus_ack. While bus_ack is low, bus_req stays high and bus_idx, bus_we and bus_wdata do not change.
- R10: The error flag is set by an acknowledge that has bus_err high. It stays set across later accesses until the block is selected again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_upd | input | 1 | Instruction-update strobe |
| ir_code | input | 5 | Instruction code valid with ir_upd |
| cap_dr | input | 1 | Data-register capture strobe |
| shf_dr | input | 1 | Data-register shift strobe |
| upd_dr | input | 1 | Data-register update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| bus_req | output | 1 | Register-bus request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_idx | output | 7 | Register index |
| bus_wdata | output | 32 | Write value |
| bus_ack | input | 1 | One-cycle acknowledge |
| bus_rdata | input | 32 | Read value, valid with bus_ack |
| bus_err | input | 1 | Unimplemented index, valid with bus_ack |

## Verification
The bench builds the block with its default widths: a 7-bit index, 32-bit data and a 34-bit chain. It attaches a register-bus model that implements 16 indices and flags every other index as an error. The model's acknowledge latency can be changed while the bench runs. A short latency gives back-to-back accesses. A latency of 60 cycles is longer than one scan, which puts a busy capture within reach for both the read path and the write path, so the repeat-scan behaviour can be checked.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/dbg_scan_shift.sv
module dbg_scan_shift #(
  parameter int DR_W = 34
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic            shf_en,
  input  logic            tdi,
  input  logic [DR_W-1:0] cap_word,
  output logic [DR_W-3:0] sr_hi,
  output logic            tdo
);
  logic [DR_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)         sr <= '0;
    else if (cap_en) sr <= cap_word;
    else if (shf_en) sr <= {tdi, sr[DR_W-1:1]};
  end

  assign tdo   = sr[0];
  assign sr_hi = sr[DR_W-1:2];

  p_capture_load_r4: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> ({sr_hi, sr[1], tdo} == $past(cap_word)));
  p_shift_in_r3: assert property (@(posedge clk) disable iff (rst)
    (shf_en && !cap_en) |=> (sr_hi[DR_W-3] == $past(tdi)));
endmodule

// File: rtl/dbg_scan_seq.sv
module dbg_scan_seq
  import dbg_scan_pkg::*;
#(
  parameter int          IR_W     = 5,
  parameter logic [4:0]  ACC_CODE = 5'h10,
  parameter int          IDX_W    = 7,
  parameter int          DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ir_upd,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              cap_dr,
  input  logic              upd_dr,
  input  logic              busy,
  input  logic              err_set,
  input  logic [DATA_W-1:0] sr_hi,
  output logic              sel,
  output phase_e            phase,
  output logic              dir_rd,
  output logic              err,
  output logic              issue_rd,
  output logic              issue_wr,
  output logic [IDX_W-1:0]  req_idx,
  output logic [DATA_W-1:0] req_wdata
);
  localparam int DIR_POS = DATA_W - 1 - IDX_W;

  logic             cap_busy;
  logic [IDX_W-1:0] idx_q;
  logic             code_hit;
  logic             upd_ok;
  logic [IDX_W-1:0] scan_idx;
  logic             scan_dir;

  assign code_hit = ir_upd && (ir_code == IR_W'(ACC_CODE));
  assign upd_ok   = sel && upd_dr && !cap_busy && !ir_upd;
  assign scan_idx = sr_hi[DATA_W-1 -: IDX_W];
  assign scan_dir = sr_hi[DIR_POS];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel      <= 1'b0;
      phase    <= PH_ADDR;
      dir_rd   <= 1'b0;
      err      <= 1'b0;
      cap_busy <= 1'b0;
      idx_q    <= '0;
    end else if (ir_upd) begin
      sel <= code_hit;
      if (code_hit) begin
        phase    <= PH_ADDR;
        err      <= 1'b0;
        cap_busy <= 1'b0;
      end
    end else begin
      if (err_set) err <= 1'b1;
      if (sel && cap_dr) cap_busy <= busy;
      if (upd_ok) begin
        if (phase == PH_ADDR) begin
          idx_q  <= scan_idx;
          dir_rd <= scan_dir;
          phase  <= PH_DATA;
        end else begin
          phase  <= PH_ADDR;
        end
      end
    end
  end

  assign issue_rd  = upd_ok && (phase == PH_ADDR) && scan_dir;
  assign issue_wr  = upd_ok && (phase == PH_DATA) && !dir_rd;
  assign req_idx   = (phase == PH_ADDR) ? scan_idx : idx_q;
  assign req_wdata = sr_hi;

  p_reselect_r2: assert property (@(posedge clk) disable iff (rst)
    code_hit |=> (phase == PH_ADDR) && !err && sel);
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (sel && upd_dr && cap_busy && !ir_upd) |=> $stable(phase));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (err && !code_hit) |=> err);
endmodule

// File: rtl/dbg_scan_busif.sv
module dbg_scan_busif #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_rd,
  input  logic              issue_wr,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err,
  output logic              bus_req,
  output logic              bus_we,
  output logic [IDX_W-1:0]  bus_idx,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic              err_set
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_idx   <= '0;
      bus_wdata <= '0;
      rdata     <= '0;
    end else if (bus_req && bus_ack) begin
      bus_req <= 1'b0;
      if (!bus_we) rdata <= bus_rdata;
    end else if (!bus_req && (issue_rd || issue_wr)) begin
      bus_req <= 1'b1;
      bus_we  <= issue_wr;
      bus_idx <= req_idx;
      if (issue_wr) bus_wdata <= req_wdata;
    end
  end

  assign busy    = bus_req;
  assign err_set = bus_req && bus_ack && bus_err;

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> bus_req && $stable(bus_idx) && $stable(bus_we)
                              && $stable(bus_wdata));
  p_single_issue_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({issue_rd, issue_wr}));
endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
  import dbg_scan_pkg::*;
#(
  parameter int          IR_W     = 5,
  parameter logic [4:0]  ACC_CODE = 5'h10,
  parameter int          IDX_W    = 7,
  parameter int          DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ir_upd,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              cap_dr,
  input  logic              shf_dr,
  input  logic              upd_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic              bus_req,
  output logic              bus_we,
  output logic [IDX_W-1:0]  bus_idx,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err
);
  localparam int DR_W = DATA_W + 2;

  logic              sel, dir_rd, err, busy, err_set;
  logic              issue_rd, issue_wr;
  phase_e            phase;
  logic [IDX_W-1:0]  req_idx;
  logic [DATA_W-1:0] req_wdata, rdata, sr_hi;
  logic [DR_W-1:0]   cap_word;

  assign cap_word = {((phase == PH_DATA) && dir_rd) ? rdata : '0, err, busy};

  dbg_scan_shift #(.DR_W(DR_W)) u_shift (
    .clk(clk), .rst(rst),
    .cap_en(sel && cap_dr), .shf_en(sel && shf_dr), .tdi(tdi),
    .cap_word(cap_word), .sr_hi(sr_hi), .tdo(tdo)
  );

  dbg_scan_seq #(
    .IR_W(IR_W), .ACC_CODE(ACC_CODE), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst(rst), .ir_upd(ir_upd), .ir_code(ir_code),
    .cap_dr(cap_dr), .upd_dr(upd_dr), .busy(busy), .err_set(err_set),
    .sr_hi(sr_hi), .sel(sel), .phase(phase), .dir_rd(dir_rd), .err(err),
    .issue_rd(issue_rd), .issue_wr(issue_wr),
    .req_idx(req_idx), .req_wdata(req_wdata)
  );

  dbg_scan_busif #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .issue_rd(issue_rd), .issue_wr(issue_wr),
    .req_idx(req_idx), .req_wdata(req_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .busy(busy), .rdata(rdata), .err_set(err_set)
  );

  p_req_from_update_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(upd_dr) && $past(sel));
endmodule

// File: tb/tb_dbg_scan_port.sv
module tb_dbg_scan_port;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 32;
  localparam int DR_W   = DATA_W + 2;
  localparam int NREG   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ir_upd = 1'b0, cap_dr = 1'b0, shf_dr = 1'b0, upd_dr = 1'b0, tdi = 1'b0;
  logic [4:0] ir_code = '0;
  logic tdo, bus_req, bus_we, bus_ack, bus_err;
  logic [IDX_W-1:0] bus_idx;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  dbg_scan_port dut (
    .clk(clk), .rst(rst), .ir_upd(ir_upd), .ir_code(ir_code),
    .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo),
    .bus_req(bus_req), .bus_we(bus_we), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  // register-bus model
  logic [DATA_W-1:0] mem [NREG];
  int lat = 2;
  int cnt;
  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0; bus_err <= 1'b0; bus_rdata <= '0; cnt <= 0;
      for (int i = 0; i < NREG; i++) mem[i] <= 32'hA500_0000 | i;
    end else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        if (cnt >= lat) begin
          bus_ack <= 1'b1; cnt <= 0;
          if (int'(bus_idx) < NREG) begin
            bus_err <= 1'b0;
            if (bus_we) mem[bus_idx] <= bus_wdata;
            bus_rdata <= mem[bus_idx];
          end else begin
            bus_err <= 1'b1; bus_rdata <= '0;
          end
        end else cnt <= cnt + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [DR_W-1:0] exp_q[$], mask_q[$], got_q[$];
  string tag_q[$];
  event scan_done;

  initial forever begin
    @(scan_done);
    while (got_q.size() > 0) begin
      logic [DR_W-1:0] g, e, m;
      string t;
      g = got_q.pop_front(); e = exp_q.pop_front();
      m = mask_q.pop_front(); t = tag_q.pop_front();
      check(((g ^ e) & m) == '0, t, 64'(g & m), 64'(e & m));
    end
  end

  task automatic scan(input logic [DR_W-1:0] din, input int nbits, output logic [DR_W-1:0] dout);
    @(negedge clk) cap_dr = 1'b1;
    @(negedge clk) cap_dr = 1'b0;
    dout = '0;
    for (int i = 0; i < nbits; i++) begin
      dout[i] = tdo; tdi = din[i]; shf_dr = 1'b1;
      @(negedge clk);
    end
    shf_dr = 1'b0; upd_dr = 1'b1;
    @(negedge clk) upd_dr = 1'b0;
  endtask

  task automatic drive_scan(input logic [DR_W-1:0] din, input int nbits,
                            input logic [DR_W-1:0] e, input logic [DR_W-1:0] m, input string t);
    logic [DR_W-1:0] d;
    exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(t);
    scan(din, nbits, d);
    got_q.push_back(d);
    ->scan_done;
  endtask

  task automatic sel_ir(input logic [4:0] code);
    @(negedge clk) begin ir_code = code; ir_upd = 1'b1; end
    @(negedge clk) ir_upd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DR_W-1:0] aw(input logic [IDX_W-1:0] idx, input logic rd);
    return {idx, rd, 26'b0};
  endfunction

  function automatic logic [DR_W-1:0] dw(input logic [DATA_W-1:0] d, input logic [1:0] st);
    return {d, st};
  endfunction

  localparam logic [DR_W-1:0] ST = 34'h3;
  localparam logic [DR_W-1:0] ALL = '1;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(tdo == 1'b0, "R1 tdo after reset", 64'(tdo), 0);
    check(bus_req == 1'b0, "R1 bus_req after reset", 64'(bus_req), 0);
    rst = 1'b0;
    sel_ir(5'h10);

    // write idx 3
    drive_scan(aw(7'd3, 1'b0), 34, 0, ST, "R1 status clear in address phase");
    drive_scan(dw(32'hDEAD_BEEF, 2'b00), 34, 0, ST, "R6 write-phase status");
    check(bus_req && bus_we, "R6 write request", 64'({bus_req, bus_we}), 64'h3);
    check(bus_idx == 7'd3, "R6 write index", 64'(bus_idx), 3);
    check(bus_wdata == 32'hDEAD_BEEF, "R6 write value", 64'(bus_wdata), 64'hDEAD_BEEF);
    idle(10);

    // read idx 3
    drive_scan(aw(7'd3, 1'b1), 34, 0, ST, "R5 address status");
    check(bus_req && !bus_we && bus_idx == 7'd3, "R5 read request",
          64'({bus_req, bus_we, bus_idx}), 64'({1'b1, 1'b0, 7'd3}));
    idle(10);
    drive_scan(dw(0, 0), 34, dw(32'hDEAD_BEEF, 2'b00), ALL, "R4 R3 read data word");

    // early-terminated read
    drive_scan(aw(7'd7, 1'b1), 34, 0, ST, "R5 address idx7");
    idle(10);
    drive_scan(dw(0, 0), 10, dw(32'hA500_0007, 2'b00), 34'h3FF, "R8 partial read bits");
    drive_scan(aw(7'd3, 1'b1), 34, 0, ST, "R8 next scan is address");
    idle(10);
    drive_scan(dw(0, 0), 34, dw(32'hDEAD_BEEF, 2'b00), ALL, "R8 read after partial");

    // busy on read
    lat = 60;
    drive_scan(aw(7'd5, 1'b1), 34, 0, ST, "R5 address idx5");
    drive_scan(dw(0, 0), 34, 34'h1, 34'h1, "R7 read busy captured");
    check(bus_req == 1'b1, "R9 request held while waiting", 64'(bus_req), 1);
    idle(80);
    drive_scan(dw(0, 0), 34, dw(32'hA500_0005, 2'b00), ALL, "R7 repeated read data");

    // busy on write
    drive_scan(aw(7'd9, 1'b0), 34, 0, ST, "R5 address idx9 write");
    drive_scan(dw(32'h1234_5678, 2'b00), 34, 0, ST, "R6 write idx9");
    drive_scan(aw(7'd9, 1'b1), 34, 34'h1, 34'h1, "R7 write busy captured");
    idle(80);
    drive_scan(aw(7'd9, 1'b1), 34, 0, ST, "R7 address repeated");
    idle(80);
    drive_scan(dw(0, 0), 34, dw(32'h1234_5678, 2'b00), ALL, "R7 read back idx9");
    lat = 2;

    // error
    drive_scan(aw(7'd100, 1'b1), 34, 0, ST, "R5 address idx100");
    idle(10);
    drive_scan(dw(0, 0), 34, dw(0, 2'b10), ALL, "R10 error flag");
    drive_scan(aw(7'd3, 1'b1), 34, 34'h2, ST, "R10 error sticky");
    idle(10);
    drive_scan(dw(0, 0), 34, dw(32'hDEAD_BEEF, 2'b10), ALL, "R10 sticky with data");

    // reselect forces address phase and clears error
    drive_scan(aw(7'd7, 1'b1), 34, 34'h2, ST, "R10 before reselect");
    idle(10);
    sel_ir(5'h10);
    drive_scan(aw(7'd3, 1'b1), 34, 0, ST, "R2 error cleared on reselect");
    idle(10);
    drive_scan(dw(0, 0), 34, dw(32'hDEAD_BEEF, 2'b00), ALL, "R2 address phase after reselect");

    // other instruction: strobes ignored
    sel_ir(5'h03);
    begin
      logic [DR_W-1:0] d;
      scan(aw(7'd5, 1'b1), 34, d);
    end
    check(bus_req == 1'b0, "R2 no request when deselected", 64'(bus_req), 0);
    idle(5);
    check(bus_req == 1'b0, "R2 still no request", 64'(bus_req), 0);
    sel_ir(5'h10);
    drive_scan(aw(7'd5, 1'b1), 34, 0, ST, "R2 reselected address");
    idle(10);
    drive_scan(dw(0, 0), 34, dw(32'hA500_0005, 2'b00), ALL, "R2 read after reselect");

    idle(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule